// File: doc/BRIEF.md
# Low-Voltage Programming Entry Key Detector

This block decides whether a device enters program/verify mode without a raised supply on its mode pin. It runs on a fast system clock and watches a slow two-wire serial link made of a clock line and a data line, together with an active-low mode pin. Both serial lines and the mode pin are brought into the system clock domain through synchronisers. While the mode pin is held low and entry is enabled by configuration, one data bit is captured on each detected falling edge of the serial clock. The programmer changes the data line on the rising edge.

After exactly 32 captured bits the collected word is compared with the fixed key 0x4D434850, which is the ASCII text "MCHP". The key is sent least significant bit first, so key bit 0 is on the line first. On an exact match the block raises its mode flag. It also gives a one-cycle entry pulse that the rest of the chip uses to clear its address counter and reset the other logic.

The flag stays up only while the mode pin stays low. A wrong key blocks all further matching until the mode pin has been released. Releasing the mode pin always returns the detector to a clean hunting state.

Top module: `lv_entry_detect`

## Requirements
- R1: After reset, prog_active and enter_pulse are both 0.
- R2: With mode_n low and lv_en 1, the 32 bits 0x4D434850 sent bit 0 first set prog_active to 1. Each bit is one serial-clock falling edge.
- R3: The data bit is taken only at the falling edge of ser_clk. The value ser_dat holds when ser_clk rises has no effect.
- R4: A 32-bit word that differs from the key in any bit leaves prog_active at 0. Every later bit is ignored until mode_n goes high, including a correct key that follows.
- R5: When mode_n goes high, prog_active returns to 0 within a few system clocks. The bit count and the shift contents are cleared, so a new attempt starts from bit 0.
- R6: With lv_en at 0, no bit pattern sets prog_active.
- R7: enter_pulse is high for exactly one system clock for each entry, in the same cycle that prog_active rises.
- R8: While prog_active is 1 and mode_n stays low, further serial traffic changes neither prog_active nor enter_pulse.
- R9: A partial key cut off by a release of mode_n is discarded. Sending only the remaining bits after mode_n goes low again does not cause entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than ser_clk |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock from the programmer (asynchronous) |
| ser_dat | input | 1 | Serial data from the programmer (asynchronous) |
| mode_n | input | 1 | Active-low mode pin; low requests and holds the mode |
| lv_en | input | 1 | Configuration bit; 1 allows low-voltage entry |
| prog_active | output | 1 | High while program/verify mode is held |
| enter_pulse | output | 1 | One-cycle pulse at entry; clears the address and resets other logic |

## Verification
Checks run on every cycle cover these rules: the mode flag drops on the cycle after a released mode pin is seen, entry only happens with the enable bit set, the entry pulse never lasts two cycles and never appears without the flag, a rejected attempt stays rejected, and the bit counter never goes past the key length. Other behaviour needs whole serial scenarios in the bench: the key order being least significant bit first, bits taken at the falling edge only, a wrong key blocking a correct key that follows, a partial key being discarded across a release, and traffic after entry being ignored.

// File: rtl/ked_pkg.sv
package ked_pkg;
    localparam int unsigned DEFAULT_KEY_W = 32;
    localparam logic [31:0] DEFAULT_KEY = 32'h4D43_4850;

    typedef enum logic [1:0] {
        ST_HUNT   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_REJECT = 2'd2
    } entry_state_e;
endpackage

// File: rtl/ked_sync.sv
module ked_sync #(
    parameter int unsigned WIDTH = 3,
    parameter int unsigned STAGES = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= async_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= RST_VAL;
                else        stage_q[s] <= stage_q[s-1];
            end
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/ked_shifter.sv
module ked_shifter #(
    parameter int unsigned KEY_W = 32,
    parameter logic [KEY_W-1:0] KEY = '0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic bit_in,
    output logic last_bit,
    output logic match
);
    localparam int unsigned CNT_W = $clog2(KEY_W + 1);

    typedef struct packed {
        logic [KEY_W-1:0] word;
        logic [CNT_W-1:0] cnt;
    } shift_t;

    shift_t sh_d, sh_q;
    logic [KEY_W-1:0] word_next;

    always_comb begin
        sh_d      = sh_q;
        word_next = {bit_in, sh_q.word[KEY_W-1:1]};
        last_bit  = shift_en && (sh_q.cnt == CNT_W'(KEY_W - 1));
        match     = last_bit && (word_next == KEY);
        if (clr) begin
            sh_d = '0;
        end else if (shift_en && (sh_q.cnt < CNT_W'(KEY_W))) begin
            sh_d.word = word_next;
            sh_d.cnt  = sh_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    p_count_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        sh_q.cnt <= CNT_W'(KEY_W));
    p_clear_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (sh_q.cnt == '0));
endmodule

// File: rtl/lv_entry_detect.sv
module lv_entry_detect #(
    parameter int unsigned KEY_W = ked_pkg::DEFAULT_KEY_W,
    parameter logic [KEY_W-1:0] KEY = KEY_W'(ked_pkg::DEFAULT_KEY),
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ser_clk,
    input  logic ser_dat,
    input  logic mode_n,
    input  logic lv_en,
    output logic prog_active,
    output logic enter_pulse
);
    import ked_pkg::*;

    typedef struct packed {
        entry_state_e st;
        logic         sclk_prev;
        logic         pulse;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic [2:0] pins_s;
    logic sclk_s, sdat_s, mode_n_s;
    logic fall, shift_en, last_bit, match;

    ked_sync #(.WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({mode_n, ser_dat, ser_clk}),
        .sync_out (pins_s)
    );

    assign sclk_s   = pins_s[0];
    assign sdat_s   = pins_s[1];
    assign mode_n_s = pins_s[2];
    assign fall     = ctl_q.sclk_prev && !sclk_s;
    assign shift_en = (ctl_q.st == ST_HUNT) && !mode_n_s && lv_en && fall;

    ked_shifter #(.KEY_W(KEY_W), .KEY(KEY)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (mode_n_s),
        .shift_en (shift_en),
        .bit_in   (sdat_s),
        .last_bit (last_bit),
        .match    (match)
    );

    always_comb begin
        ctl_d           = ctl_q;
        ctl_d.sclk_prev = sclk_s;
        ctl_d.pulse     = 1'b0;
        if (mode_n_s) begin
            ctl_d.st = ST_HUNT;
        end else begin
            unique case (ctl_q.st)
                ST_HUNT: begin
                    if (match) begin
                        ctl_d.st    = ST_ACTIVE;
                        ctl_d.pulse = 1'b1;
                    end else if (last_bit) begin
                        ctl_d.st = ST_REJECT;
                    end
                end
                ST_ACTIVE: ctl_d.st = ST_ACTIVE;
                ST_REJECT: ctl_d.st = ST_REJECT;
                default:   ctl_d.st = ST_HUNT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= '{st: ST_HUNT, sclk_prev: 1'b0, pulse: 1'b0};
        else        ctl_q <= ctl_d;
    end

    assign prog_active = (ctl_q.st == ST_ACTIVE);
    assign enter_pulse = ctl_q.pulse;

    p_release_exits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        mode_n_s |=> !prog_active);
    p_entry_needs_en_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(prog_active) |-> $past(lv_en));
    p_pulse_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |=> !enter_pulse);
    p_pulse_with_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        enter_pulse |-> prog_active);
    p_reject_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == ST_REJECT && !mode_n_s) |=> !prog_active);
endmodule

// File: tb/lv_entry_detect_test.sv
module lv_entry_detect_test;
    localparam logic [31:0] KEY = 32'h4D43_4850;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, mode_n = 1'b1, lv_en = 1'b1;
    logic prog_active, enter_pulse;
    int checks = 0, fails = 0, pulses = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    lv_entry_detect uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .mode_n(mode_n), .lv_en(lv_en),
        .prog_active(prog_active), .enter_pulse(enter_pulse)
    );

    always @(negedge clk) if (rst_n && enter_pulse) pulses++;

    function automatic logic exp_entry(logic [31:0] w, logic en);
        return en && (w == KEY);
    endfunction

    task automatic chk(string req, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0b expected %0b", req, act, exp);
        end
    endtask

    task automatic waitc(int n);
        repeat (n) @(negedge clk);
    endtask

    // data changes at the rising edge; optionally a decoy value before the true bit
    task automatic send_bit(logic b, bit decoy);
        ser_clk = 1'b1;
        ser_dat = decoy ? ~b : b;
        waitc(3);
        ser_dat = b;
        waitc(3);
        ser_clk = 1'b0;
        waitc(6);
    endtask

    task automatic send_bits(logic [31:0] w, int first, int last, bit decoy);
        for (int i = first; i <= last; i++) send_bit(w[i], decoy);
    endtask

    task automatic press;
        mode_n = 1'b0;
        waitc(8);
    endtask

    task automatic release_pin;
        mode_n = 1'b1;
        waitc(8);
    endtask

    initial begin
        int p0;
        logic [31:0] w;
        logic en;
        void'($urandom(32'd2718));
        waitc(3);
        chk("R1 reset prog_active", prog_active, 1'b0);
        chk("R1 reset enter_pulse", enter_pulse, 1'b0);
        rst_n = 1'b1;
        waitc(4);

        // R2 + R7: the correct key
        p0 = pulses;
        press();
        send_bits(KEY, 0, 31, 1'b0);
        chk("R2 key entry", prog_active, 1'b1);
        chk("R7 one pulse", (pulses - p0) == 1, 1'b1);
        // R8: traffic after entry
        send_bits(32'hFFFF_0000, 0, 31, 1'b0);
        chk("R8 stays active", prog_active, 1'b1);
        chk("R8 no extra pulse", (pulses - p0) == 1, 1'b1);
        release_pin();
        chk("R5 release exits", prog_active, 1'b0);

        // R2: the same value sent most significant bit first must fail
        press();
        send_bits({<<{KEY}}, 0, 31, 1'b0);
        chk("R2 reversed order rejected", prog_active, 1'b0);
        release_pin();

        // R3: decoy value present at the rising edge
        press();
        send_bits(KEY, 0, 31, 1'b1);
        chk("R3 falling-edge sample", prog_active, 1'b1);
        release_pin();

        // R4: a wrong key then the correct key
        press();
        send_bits(KEY ^ 32'h0000_0100, 0, 31, 1'b0);
        chk("R4 wrong key", prog_active, 1'b0);
        send_bits(KEY, 0, 31, 1'b0);
        chk("R4 locked after mismatch", prog_active, 1'b0);
        release_pin();
        // R5: a fresh attempt works after release
        press();
        send_bits(KEY, 0, 31, 1'b0);
        chk("R5 new attempt after release", prog_active, 1'b1);
        release_pin();

        // R6: enable low
        lv_en = 1'b0;
        press();
        send_bits(KEY, 0, 31, 1'b0);
        chk("R6 disabled entry", prog_active, 1'b0);
        release_pin();
        lv_en = 1'b1;

        // R9: partial key cut by a release
        press();
        send_bits(KEY, 0, 15, 1'b0);
        release_pin();
        press();
        send_bits(KEY, 16, 31, 1'b0);
        chk("R9 partial key discarded", prog_active, 1'b0);
        release_pin();

        // random mix of near-keys, random words and the enable bit
        for (int t = 0; t < 16; t++) begin
            int k;
            k  = $urandom_range(0, 2);
            en = ($urandom_range(0, 3) != 0);
            w  = (k == 0) ? KEY : (k == 1) ? (KEY ^ (32'd1 << $urandom_range(0, 31))) : $urandom;
            lv_en = en;
            p0 = pulses;
            press();
            send_bits(w, 0, 31, 1'b0);
            chk("R2 R4 R6 random word", prog_active, exp_entry(w, en));
            chk("R7 random pulse count", (pulses - p0) == int'(exp_entry(w, en)), 1'b1);
            release_pin();
            chk("R5 random release", prog_active, 1'b0);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule